// File: doc/BRIEF.md
# PWM Event and Update Router

This block sits beside one PWM generator and decides which of its timing events reach three consumers. The first is the interrupt request. The second is the generator trigger output that other blocks listen to. The third is the update request, which tells the generator to take new period, phase and duty values.

The time base sends single-cycle event pulses into the block:
- end of cycle;
- compare A to F;
- ADC trigger 1;
- five protection-class events: sync, fault 1, fault 2, current limit and feed-forward.

The register file sends write strobes for the local and master duty, phase and period registers and for the compare A register, together with three master-select bits. A 13-bit configuration word, written through a single write-enable port, holds the routing choices. Each output is a registered one-cycle pulse and appears on the clock edge after the event that causes it.

Configuration word layout, from the least significant bit:

| Bits | Field | Meaning |
|------|-------|---------|
| [1:0] | time-base interrupt select | 0 end of cycle, 1 compare A, 2 ADC trigger 1, 3 off |
| [6:2] | protection interrupt enables | bit 2 sync, bit 3 fault 1, bit 4 fault 2, bit 5 current limit, bit 6 feed-forward |
| [9:7] | trigger-output select | 0 end of cycle, 1 to 6 compare A to F, 7 reserved |
| [11:10] | update trigger select | see R9 to R12 |
| [12] | manual update request | not stored |

The event inputs carry the events in the same order as the enables: `prot_evt_i` bit 0 is sync, bit 1 fault 1, bit 2 fault 2, bit 3 current limit and bit 4 feed-forward. `cmp_evt_i` bit 0 is compare A and bit 5 is compare F.

Top module: `pwm_evt_router`

## Requirements
- R1: With interrupt select 0, an end-of-cycle pulse gives `irq_o` high for one cycle on the next clock edge, and compare A alone gives none.
- R2: With interrupt select 1, compare A gives an interrupt pulse, and end of cycle alone gives none.
- R3: With interrupt select 2, an ADC trigger 1 pulse gives an interrupt pulse.
- R4: With interrupt select 3, no time-base event (end of cycle, compare A, ADC trigger 1) gives an interrupt.
- R5: A protection event gives an interrupt pulse only when its own enable bit is 1, whatever the interrupt select is.
- R6: When a selected time-base event and an enabled protection event come in the same cycle, they give one single-cycle interrupt pulse.
- R7: Trigger-output select 0 passes end of cycle to `trg_o`, and select n from 1 to 6 passes compare event n (cmp_evt_i bit n-1). Other sources give no pulse.
- R8: Trigger-output select 7 is reserved and never asserts `trg_o`.
- R9: Update select 1 raises `upd_o` on the next edge after a master duty write when `msel_duty_i` is 1, or after a local duty write when it is 0. A write to the other register of the pair does not raise it.
- R10: Update select 2 raises `upd_o` after a master phase write when `msel_phase_i` is 1, or after a local phase write when it is 0. A write to the other register of the pair does not raise it.
- R11: Update select 3 raises `upd_o` after a master period write when `msel_per_i` is 1, or after a compare A register write when it is 0. A write to the other register of the pair does not raise it.
- R12: Update select 0 ignores all register write strobes. Writing the configuration with bit 12 set raises `upd_o` for exactly one cycle, two edges after the write, and the request then clears itself.
- R13: After reset every configuration field is zero, so end of cycle drives both `irq_o` and `trg_o`, and no output is high with idle inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 13 | Configuration word |
| eoc_i | input | 1 | End-of-cycle pulse |
| cmp_evt_i | input | 6 | Compare A to F pulses; bit 0 is compare A |
| adc_trg1_i | input | 1 | ADC trigger 1 pulse |
| prot_evt_i | input | 5 | Sync, fault 1, fault 2, current limit, feed-forward pulses |
| wr_duty_i | input | 1 | Local duty register write strobe |
| wr_mduty_i | input | 1 | Master duty register write strobe |
| wr_phase_i | input | 1 | Local phase register write strobe |
| wr_mphase_i | input | 1 | Master phase register write strobe |
| wr_mper_i | input | 1 | Master period register write strobe |
| wr_cmpa_i | input | 1 | Compare A register write strobe |
| msel_duty_i | input | 1 | Use the master duty register |
| msel_phase_i | input | 1 | Use the master phase register |
| msel_per_i | input | 1 | Use the master period register |
| irq_o | output | 1 | Interrupt request pulse |
| trg_o | output | 1 | Generator trigger-output pulse |
| upd_o | output | 1 | Update request pulse |

## Verification
The interrupt path can see a selected time-base event and an enabled protection event in the same cycle. The bench drives end of cycle and sync together, with select 0 and the sync enable set. It passes only if `irq_o` is high on the next cycle and low on the cycle after that, so two sources may not stretch or double the pulse.

The update path also has a possible collision: a manual request set while the matching register is written. The bench judges this by checking that `upd_o` comes on the expected edges and that the manual request never repeats.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

   localparam int NUM_PROT = 5;
   localparam int IRQ_W    = 2;
   localparam int TRG_W    = 3;
   localparam int UPD_W    = 2;
   localparam int CFG_REG_W = UPD_W + TRG_W + NUM_PROT + IRQ_W;
   localparam int MAN_BIT  = CFG_REG_W;
   localparam int CFG_W    = CFG_REG_W + 1;

   typedef enum logic [IRQ_W-1:0] {
      IRQ_EOC  = 2'd0,
      IRQ_CMPA = 2'd1,
      IRQ_ADC  = 2'd2,
      IRQ_OFF  = 2'd3
   } irq_sel_e;

   typedef enum logic [UPD_W-1:0] {
      UPD_MANUAL = 2'd0,
      UPD_DUTY   = 2'd1,
      UPD_PHASE  = 2'd2,
      UPD_PERIOD = 2'd3
   } upd_sel_e;

   typedef struct packed {
      upd_sel_e              upd_sel;
      logic [TRG_W-1:0]      trg_sel;
      logic [NUM_PROT-1:0]   prot_en;
      irq_sel_e              irq_sel;
   } cfg_t;

endpackage

// File: rtl/pwm_evt_irq.sv
module pwm_evt_irq
   import pwm_evt_pkg::*;
#(
   parameter int NUM_CMP = 6
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  irq_sel_e            sel_i,
   input  logic [NUM_PROT-1:0] prot_en_i,
   input  logic                eoc_i,
   input  logic                cmpa_i,
   input  logic                adc_i,
   input  logic [NUM_PROT-1:0] prot_i,
   output logic                irq_o
);

   generate
      if (NUM_CMP < 1) begin : g_bad_cmp
         $error("pwm_evt_irq: NUM_CMP must be at least 1");
      end
   endgenerate

   logic tb_hit;
   logic prot_hit;
   logic irq_q;

   always_comb begin
      unique case (sel_i)
         IRQ_EOC:  tb_hit = eoc_i;
         IRQ_CMPA: tb_hit = cmpa_i;
         IRQ_ADC:  tb_hit = adc_i;
         default:  tb_hit = 1'b0;
      endcase
   end

   assign prot_hit = |(prot_i & prot_en_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= tb_hit | prot_hit;
   end

   assign irq_o = irq_q;

   // R4
   irq_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == IRQ_OFF && (prot_i & prot_en_i) == '0) |=> !irq_o);

   // R1
   irq_eoc_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == IRQ_EOC && eoc_i) |=> irq_o);

   // R5
   irq_prot_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((prot_i & prot_en_i) != '0) |=> irq_o);

endmodule

// File: rtl/pwm_evt_trg.sv
module pwm_evt_trg
   import pwm_evt_pkg::*;
#(
   parameter int NUM_CMP = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [TRG_W-1:0]   sel_i,
   input  logic               eoc_i,
   input  logic [NUM_CMP-1:0] cmp_i,
   output logic               trg_o
);

   localparam int NUM_CODE = 2 ** TRG_W;
   localparam int LAST_VALID = NUM_CMP;

   generate
      if (NUM_CMP + 1 > NUM_CODE) begin : g_bad_width
         $error("pwm_evt_trg: too many compare events for the select width");
      end
   endgenerate

   logic [NUM_CODE-1:0] src;

   generate
      for (genvar g = 0; g < NUM_CODE; g++) begin : g_src
         if (g == 0) begin : g_eoc
            assign src[g] = eoc_i;
         end else if (g <= NUM_CMP) begin : g_cmp
            assign src[g] = cmp_i[g-1];
         end else begin : g_rsv
            assign src[g] = 1'b0;
         end
      end
   endgenerate

   logic trg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trg_q <= 1'b0;
      else         trg_q <= src[sel_i];
   end

   assign trg_o = trg_q;

   // R8
   trg_reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_i) > LAST_VALID) |=> !trg_o);

   // R7
   trg_eoc_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == '0 && eoc_i) |=> trg_o);

endmodule

// File: rtl/pwm_evt_upd.sv
module pwm_evt_upd
   import pwm_evt_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  upd_sel_e sel_i,
   input  logic     manual_i,
   input  logic     wr_duty_i,
   input  logic     wr_mduty_i,
   input  logic     wr_phase_i,
   input  logic     wr_mphase_i,
   input  logic     wr_mper_i,
   input  logic     wr_cmpa_i,
   input  logic     msel_duty_i,
   input  logic     msel_phase_i,
   input  logic     msel_per_i,
   output logic     upd_o
);

   logic wr_hit;
   logic upd_q;

   always_comb begin
      unique case (sel_i)
         UPD_DUTY:   wr_hit = msel_duty_i  ? wr_mduty_i  : wr_duty_i;
         UPD_PHASE:  wr_hit = msel_phase_i ? wr_mphase_i : wr_phase_i;
         UPD_PERIOD: wr_hit = msel_per_i   ? wr_mper_i   : wr_cmpa_i;
         default:    wr_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) upd_q <= 1'b0;
      else         upd_q <= wr_hit | manual_i;
   end

   assign upd_o = upd_q;

   // R12
   upd_manual_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == UPD_MANUAL && !manual_i) |=> !upd_o);

   // R9
   upd_duty_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == UPD_DUTY && msel_duty_i && wr_mduty_i) |=> upd_o);

endmodule

// File: rtl/pwm_evt_router.sv
module pwm_evt_router
   import pwm_evt_pkg::*;
#(
   parameter int NUM_CMP = 6
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cfg_we_i,
   input  logic [CFG_W-1:0]    cfg_wdata_i,
   input  logic                eoc_i,
   input  logic [NUM_CMP-1:0]  cmp_evt_i,
   input  logic                adc_trg1_i,
   input  logic [NUM_PROT-1:0] prot_evt_i,
   input  logic                wr_duty_i,
   input  logic                wr_mduty_i,
   input  logic                wr_phase_i,
   input  logic                wr_mphase_i,
   input  logic                wr_mper_i,
   input  logic                wr_cmpa_i,
   input  logic                msel_duty_i,
   input  logic                msel_phase_i,
   input  logic                msel_per_i,
   output logic                irq_o,
   output logic                trg_o,
   output logic                upd_o
);

   cfg_t cfg_q;
   logic manual_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q    <= '0;
         manual_q <= 1'b0;
      end else begin
         if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i[CFG_REG_W-1:0]);
         manual_q <= cfg_we_i & cfg_wdata_i[MAN_BIT];
      end
   end

   pwm_evt_irq #(.NUM_CMP(NUM_CMP)) u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (cfg_q.irq_sel),
      .prot_en_i (cfg_q.prot_en),
      .eoc_i     (eoc_i),
      .cmpa_i    (cmp_evt_i[0]),
      .adc_i     (adc_trg1_i),
      .prot_i    (prot_evt_i),
      .irq_o     (irq_o)
   );

   pwm_evt_trg #(.NUM_CMP(NUM_CMP)) u_trg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (cfg_q.trg_sel),
      .eoc_i  (eoc_i),
      .cmp_i  (cmp_evt_i),
      .trg_o  (trg_o)
   );

   pwm_evt_upd u_upd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (cfg_q.upd_sel),
      .manual_i     (manual_q),
      .wr_duty_i    (wr_duty_i),
      .wr_mduty_i   (wr_mduty_i),
      .wr_phase_i   (wr_phase_i),
      .wr_mphase_i  (wr_mphase_i),
      .wr_mper_i    (wr_mper_i),
      .wr_cmpa_i    (wr_cmpa_i),
      .msel_duty_i  (msel_duty_i),
      .msel_phase_i (msel_phase_i),
      .msel_per_i   (msel_per_i),
      .upd_o        (upd_o)
   );

   // R12
   manual_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      manual_q |=> upd_o);

   // R12
   manual_selfclear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (manual_q && !cfg_we_i) |=> !manual_q);

endmodule

// File: tb/pwm_evt_router_tb_top.sv
module pwm_evt_router_tb_top;
   import pwm_evt_pkg::*;

   localparam int NC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic eoc = 1'b0;
   logic [NC-1:0] cmp = '0;
   logic adc = 1'b0;
   logic [NUM_PROT-1:0] prot = '0;
   logic [5:0] wr = '0;
   logic [2:0] msel = '0;
   logic irq, trg, upd;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_evt_router #(.NUM_CMP(NC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .eoc_i(eoc), .cmp_evt_i(cmp), .adc_trg1_i(adc), .prot_evt_i(prot),
      .wr_duty_i(wr[0]), .wr_mduty_i(wr[1]), .wr_phase_i(wr[2]),
      .wr_mphase_i(wr[3]), .wr_mper_i(wr[4]), .wr_cmpa_i(wr[5]),
      .msel_duty_i(msel[0]), .msel_phase_i(msel[1]), .msel_per_i(msel[2]),
      .irq_o(irq), .trg_o(trg), .upd_o(upd)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [CFG_W-1:0] mk(input int isel, input int pen,
                                          input int tsel, input int usel,
                                          input bit man);
      logic [CFG_W-1:0] w;
      w = '0;
      w[1:0]   = isel[1:0];
      w[6:2]   = pen[4:0];
      w[9:7]   = tsel[2:0];
      w[11:10] = usel[1:0];
      w[12]    = man;
      return w;
   endfunction

   task automatic set_cfg(input logic [CFG_W-1:0] w);
      cfg_we = 1'b1;
      cfg_wdata = w;
      tick();
      cfg_we = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic fire(input logic e, input logic [NC-1:0] c, input logic a,
                       input logic [NUM_PROT-1:0] p);
      eoc = e; cmp = c; adc = a; prot = p;
      tick();
      eoc = 1'b0; cmp = '0; adc = 1'b0; prot = '0;
   endtask

   task automatic strobe(input logic [5:0] w);
      wr = w;
      tick();
      wr = '0;
   endtask

   task automatic t_reset();
      chk("R13 idle irq", irq, 1'b0);
      chk("R13 idle trg", trg, 1'b0);
      chk("R13 idle upd", upd, 1'b0);
      fire(1'b1, '0, 1'b0, '0);
      chk("R13 eoc irq", irq, 1'b1);
      chk("R13 eoc trg", trg, 1'b1);
      chk("R13 eoc upd", upd, 1'b0);
   endtask

   task automatic t_irq_select();
      set_cfg(mk(0, 0, 7, 0, 0));
      fire(1'b1, '0, 1'b0, '0);        chk("R1 eoc", irq, 1'b1);
      fire(1'b0, 6'b000001, 1'b0, '0); chk("R1 cmpa ignored", irq, 1'b0);
      set_cfg(mk(1, 0, 7, 0, 0));
      fire(1'b0, 6'b000001, 1'b0, '0); chk("R2 cmpa", irq, 1'b1);
      fire(1'b1, '0, 1'b0, '0);        chk("R2 eoc ignored", irq, 1'b0);
      fire(1'b0, 6'b000010, 1'b0, '0); chk("R2 cmpb ignored", irq, 1'b0);
      set_cfg(mk(2, 0, 7, 0, 0));
      fire(1'b0, '0, 1'b1, '0);        chk("R3 adc", irq, 1'b1);
      fire(1'b1, 6'b000001, 1'b0, '0); chk("R3 others ignored", irq, 1'b0);
      set_cfg(mk(3, 0, 7, 0, 0));
      fire(1'b1, 6'b111111, 1'b1, '0); chk("R4 all tb off", irq, 1'b0);
   endtask

   task automatic t_prot();
      for (int en = 0; en < NUM_PROT; en++) begin
         set_cfg(mk(3, 1 << en, 7, 0, 0));
         for (int ev = 0; ev < NUM_PROT; ev++) begin
            fire(1'b0, '0, 1'b0, NUM_PROT'(1 << ev));
            chk($sformatf("R5 en%0d ev%0d", en, ev), irq, logic'(en == ev));
         end
      end
      set_cfg(mk(1, 5'b00010, 7, 0, 0));
      fire(1'b0, '0, 1'b0, 5'b00010);  chk("R5 fault1 with sel1", irq, 1'b1);
   endtask

   task automatic t_coincide();
      set_cfg(mk(0, 5'b00001, 7, 0, 0));
      fire(1'b1, '0, 1'b0, 5'b00001);
      chk("R6 joint pulse", irq, 1'b1);
      tick();
      chk("R6 single cycle", irq, 1'b0);
   endtask

   task automatic t_trg();
      for (int code = 0; code <= NC; code++) begin
         set_cfg(mk(3, 0, code, 0, 0));
         for (int s = 0; s <= NC; s++) begin
            if (s == 0) fire(1'b1, '0, 1'b0, '0);
            else        fire(1'b0, NC'(1 << (s - 1)), 1'b0, '0);
            chk($sformatf("R7 code%0d src%0d", code, s), trg, logic'(code == s));
         end
      end
      set_cfg(mk(3, 0, 7, 0, 0));
      fire(1'b1, 6'b111111, 1'b1, 5'b11111);
      chk("R8 reserved trg", trg, 1'b0);
   endtask

   task automatic t_upd_pair(input string tag, input int usel, input int mbit,
                             input int loc, input int mst);
      set_cfg(mk(3, 0, 7, usel, 0));
      msel = '0;
      strobe(6'(1 << loc)); chk({tag, " local hit"}, upd, 1'b1);
      strobe(6'(1 << mst)); chk({tag, " master ignored"}, upd, 1'b0);
      msel = 3'(1 << mbit);
      strobe(6'(1 << mst)); chk({tag, " master hit"}, upd, 1'b1);
      strobe(6'(1 << loc)); chk({tag, " local ignored"}, upd, 1'b0);
      msel = '0;
   endtask

   task automatic t_manual();
      set_cfg(mk(3, 0, 7, 0, 0));
      strobe(6'b111111);
      chk("R12 writes ignored", upd, 1'b0);
      msel = 3'b111;
      strobe(6'b111111);
      chk("R12 master writes ignored", upd, 1'b0);
      msel = '0;
      set_cfg(mk(3, 0, 7, 0, 1));
      chk("R12 not yet", upd, 1'b0);
      tick();
      chk("R12 manual pulse", upd, 1'b1);
      tick();
      chk("R12 self clear", upd, 1'b0);
      tick();
      chk("R12 stays clear", upd, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_irq_select();
      t_prot();
      t_coincide();
      t_trg();
      t_upd_pair("R9", 1, 0, 0, 1);
      t_upd_pair("R10", 2, 1, 2, 3);
      t_upd_pair("R11", 3, 2, 5, 4);
      t_manual();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule